// File: doc/BRIEF.md
# Fused Multiply-Add Mantissa Datapath

This block computes the normal-operand core of a single-precision fused multiply-add. It receives, for three operands x, y and z, unbiased signed exponents and 24-bit mantissas whose hidden bit is already set. It also receives the sign of the product, the sign of the addend, a flag saying that z is zero, and a flag saying that the active rounding mode rounds toward minus infinity. It returns a sign, a signed exponent and a 27-bit mantissa. That mantissa is 24 significant bits followed by guard, round and sticky bits, and it goes to a separate rounder.

The exact 48-bit product sits in a 64-bit frame with its leading one at bit 62. The addend is placed in the same frame. Whichever operand has the smaller exponent is moved right by a shift that keeps a sticky bit. The two are then added or subtracted once, renormalized, and only at the end reduced to 27 bits. Special operands and rounding are handled by neighbouring blocks. One result register sits between the inputs and the outputs. A valid strobe travels with each operation.

Top module: `fma_mant_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid` is 0 and the result outputs are all zero.
- R2: A result appears with `outValid` high exactly one clock after `inValid` was high. When `inValid` is low, `outValid` is low in the next cycle and `outSign`, `outExp` and `outMant` keep their previous values.
- R3: With `zIsZero` set, the result is the product alone. Its sign is `prodSign` and its exponent is xExp+yExp, plus one when the product mantissa reaches 2.0 or more. Its mantissa has the leading one at bit 26.
- R4: The operand with the smaller exponent is shifted right by the exponent difference. Every bit shifted out is ORed into bit 0. A difference of 64 or more leaves only that sticky bit. The result carries the larger exponent.
- R5: When `prodSign` equals `addSign`, the magnitudes are added. A carry past the leading position gives a one-place right shift that keeps sticky, and the exponent is incremented.
- R6: When the signs differ, the smaller magnitude is taken from the larger and the result takes the sign of the larger. The difference is shifted left until the leading one returns to bit 26 of the output, and the exponent drops by the same count.
- R7: An exact zero difference gives `outMant` = 0 and `outExp` = 0. Its sign is 1 only when `roundDown` is set.
- R8: When the 64-bit frame is reduced to 27 bits, the 36 lowest bits are dropped and their OR becomes `outMant[0]`.
- R9: The exponent is a signed 10-bit value. Results outside the single-precision exponent range, such as -300, reach the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands are valid this cycle |
| xExp | input | 10 | Unbiased exponent of x, signed |
| yExp | input | 10 | Unbiased exponent of y, signed |
| zExp | input | 10 | Unbiased exponent of z, signed |
| xMant | input | 24 | Mantissa of x with hidden bit |
| yMant | input | 24 | Mantissa of y with hidden bit |
| zMant | input | 24 | Mantissa of z with hidden bit |
| prodSign | input | 1 | Sign of x times y |
| addSign | input | 1 | Sign of the addend z |
| zIsZero | input | 1 | The addend is zero |
| roundDown | input | 1 | Rounding mode is toward minus infinity |
| outValid | output | 1 | Result is valid |
| outSign | output | 1 | Result sign |
| outExp | output | 10 | Result exponent, signed |
| outMant | output | 27 | Result mantissa with guard, round and sticky bits |

## Verification
In a single operation, a carry out of the fused add and the sticky collection of the final 36-bit reduction can both act. Two 1+2^-23 mantissas multiplied and added to 1.0 produce a sum past bit 63 that also has low bits set. The expected mantissa 0x4000009 with exponent 1 shows that the carry shift and the sticky OR were applied together and in the right order. A second case combines alignment sticky with reduction sticky by moving the product 100 places, beyond the frame. Only a set bit 0 on top of z's mantissa should remain.

// File: rtl/fma_pkg.sv
package fma_pkg;

  typedef struct packed {
    logic capture;
    logic validNext;
  } fmaStrobe_t;

  function automatic logic [63:0] stickyShr(input logic [63:0] v, input logic [11:0] amt);
    logic [63:0] res;
    logic [63:0] mask;
    if (amt >= 12'd64) begin
      res = {63'b0, |v};
    end else begin
      mask = (64'b1 << amt[5:0]) - 64'b1;
      res = v >> amt[5:0];
      res[0] = res[0] | (|(v & mask));
    end
    return res;
  endfunction

  function automatic logic [6:0] leadZeros(input logic [63:0] v, input int top);
    logic [6:0] cnt;
    logic found;
    cnt = '0;
    found = 1'b0;
    for (int i = 63; i >= 0; i--) begin
      if (i <= top && !found) begin
        if (v[i]) found = 1'b1;
        else cnt = cnt + 7'd1;
      end
    end
    return cnt;
  endfunction

endpackage

// File: rtl/fma_ctrl.sv
module fma_ctrl
  import fma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output fmaStrobe_t strobe,
  output logic       outValid
);

  always_comb begin
    strobe.capture   = inValid;
    strobe.validNext = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobe.validNext;
  end

endmodule

// File: rtl/fma_dp.sv
module fma_dp
  import fma_pkg::*;
#(
  parameter int MantW = 24,
  parameter int ExpW  = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fmaStrobe_t             strobe,
  input  logic signed [ExpW-1:0] xExp,
  input  logic signed [ExpW-1:0] yExp,
  input  logic signed [ExpW-1:0] zExp,
  input  logic [MantW-1:0]       xMant,
  input  logic [MantW-1:0]       yMant,
  input  logic [MantW-1:0]       zMant,
  input  logic                   prodSign,
  input  logic                   addSign,
  input  logic                   zIsZero,
  input  logic                   roundDown,
  output logic                   outSign,
  output logic signed [ExpW-1:0] outExp,
  output logic [MantW+2:0]       outMant
);

  localparam int FrameW    = 64;
  localparam int LeadPos   = FrameW - 2;
  localparam int OutW      = MantW + 3;
  localparam int DropW     = LeadPos - (OutW - 1);
  localparam int ZShift    = LeadPos - (MantW - 1);
  localparam int ProdShift = FrameW - 2 * MantW;
  localparam int IntW      = ExpW + 2;

  logic [2*MantW-1:0]     prodFull;
  logic [FrameW-1:0]      prodFrame, addFrame, sumFrame, resFrame, reduced;
  logic signed [IntW-1:0] prodE, addE, commonE, resE, diffE;
  logic [6:0]             lz;
  logic                   resSign, isZeroRes;

  always_comb begin
    prodFull  = xMant * yMant;
    prodFrame = FrameW'(prodFull) << ProdShift;
    prodE     = IntW'(xExp) + IntW'(yExp);
    if (prodFrame[FrameW-1]) begin
      prodFrame = prodFrame >> 1;
      prodE     = prodE + IntW'(1);
    end
    addFrame  = FrameW'(zMant) << ZShift;
    addE      = IntW'(zExp);
    sumFrame  = '0;
    resFrame  = prodFrame;
    resE      = prodE;
    resSign   = prodSign;
    isZeroRes = 1'b0;
    commonE   = prodE;
    diffE     = '0;
    lz        = '0;
    if (!zIsZero) begin
      if (addE > prodE) begin
        diffE     = addE - prodE;
        prodFrame = stickyShr(prodFrame, 12'(diffE));
        commonE   = addE;
      end else begin
        diffE    = prodE - addE;
        addFrame = stickyShr(addFrame, 12'(diffE));
        commonE  = prodE;
      end
      if (addSign == prodSign) begin
        sumFrame = addFrame + prodFrame;
        resSign  = addSign;
        resE     = commonE;
        if (sumFrame[FrameW-1]) begin
          sumFrame = stickyShr(sumFrame, 12'd1);
          resE     = resE + IntW'(1);
        end
        resFrame = sumFrame;
      end else begin
        if (addFrame >= prodFrame) begin
          sumFrame = addFrame - prodFrame;
          resSign  = addSign;
        end else begin
          sumFrame = prodFrame - addFrame;
          resSign  = prodSign;
        end
        if (sumFrame == '0) begin
          isZeroRes = 1'b1;
          resSign   = roundDown;
          resE      = '0;
          resFrame  = '0;
        end else begin
          lz       = leadZeros(sumFrame, LeadPos);
          resFrame = sumFrame << lz;
          resE     = commonE - IntW'(lz);
        end
      end
    end
    reduced = isZeroRes ? '0 : stickyShr(resFrame, 12'(DropW));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSign <= 1'b0;
      outExp  <= '0;
      outMant <= '0;
    end else if (strobe.capture) begin
      outSign <= resSign;
      outExp  <= resE[ExpW-1:0];
      outMant <= reduced[OutW-1:0];
    end
  end

endmodule

// File: rtl/fma_mant_top.sv
module fma_mant_top
  import fma_pkg::*;
#(
  parameter int MantW = 24,
  parameter int ExpW  = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic signed [ExpW-1:0] xExp,
  input  logic signed [ExpW-1:0] yExp,
  input  logic signed [ExpW-1:0] zExp,
  input  logic [MantW-1:0]       xMant,
  input  logic [MantW-1:0]       yMant,
  input  logic [MantW-1:0]       zMant,
  input  logic                   prodSign,
  input  logic                   addSign,
  input  logic                   zIsZero,
  input  logic                   roundDown,
  output logic                   outValid,
  output logic                   outSign,
  output logic signed [ExpW-1:0] outExp,
  output logic [MantW+2:0]       outMant
);

  fmaStrobe_t strobe;

  fma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  fma_dp #(.MantW(MantW), .ExpW(ExpW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .xExp(xExp), .yExp(yExp), .zExp(zExp),
    .xMant(xMant), .yMant(yMant), .zMant(zMant),
    .prodSign(prodSign), .addSign(addSign),
    .zIsZero(zIsZero), .roundDown(roundDown),
    .outSign(outSign), .outExp(outExp), .outMant(outMant)
  );

endmodule

// File: rtl/fma_mant_checker.sv
module fma_mant_checker #(
  parameter int MantW = 24,
  parameter int ExpW  = 10
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   prodSign,
  input logic                   zIsZero,
  input logic                   outValid,
  input logic                   outSign,
  input logic signed [ExpW-1:0] outExp,
  input logic [MantW+2:0]       outMant
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outMant) && $stable(outExp) && $stable(outSign))); // R2

  AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outMant != '0) |-> outMant[MantW+2]); // R6

  AST_ZERO_EXP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outMant == '0) |-> (outExp == '0)); // R7

  AST_PROD_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && zIsZero) |=> (outSign == $past(prodSign))); // R3

endmodule

bind fma_mant_top fma_mant_checker #(.MantW(MantW), .ExpW(ExpW)) u_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .prodSign(prodSign),
  .zIsZero(zIsZero), .outValid(outValid), .outSign(outSign),
  .outExp(outExp), .outMant(outMant)
);

// File: tb/fma_mant_top_bench.sv
module fma_mant_top_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [9:0] xExp = '0, yExp = '0, zExp = '0;
  logic [23:0] xMant = '0, yMant = '0, zMant = '0;
  logic prodSign = 1'b0, addSign = 1'b0, zIsZero = 1'b0, roundDown = 1'b0;
  logic outValid, outSign;
  logic signed [9:0] outExp;
  logic [26:0] outMant;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fma_mant_top u_fma_mant_top (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .xExp(xExp), .yExp(yExp), .zExp(zExp),
    .xMant(xMant), .yMant(yMant), .zMant(zMant),
    .prodSign(prodSign), .addSign(addSign), .zIsZero(zIsZero),
    .roundDown(roundDown), .outValid(outValid), .outSign(outSign),
    .outExp(outExp), .outMant(outMant)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic runOp(input string tag,
      input logic [23:0] xm, input int xe, input logic [23:0] ym, input int ye,
      input logic [23:0] zm, input int ze, input logic ps, input logic zs,
      input logic zz, input logic rd,
      input logic eSign, input int eExp, input logic [26:0] eMant);
    @(negedge clk);
    xMant = xm; xExp = 10'(xe); yMant = ym; yExp = 10'(ye);
    zMant = zm; zExp = 10'(ze); prodSign = ps; addSign = zs;
    zIsZero = zz; roundDown = rd; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(tag, "valid", longint'(outValid), 1);
    check(tag, "sign", longint'(outSign), longint'(eSign));
    check(tag, "exp", longint'(int'(outExp)), longint'(eExp));
    check(tag, "mant", longint'(outMant), longint'(eMant));
  endtask

  task automatic testReset();
    check("R1", "valid", longint'(outValid), 0);
    check("R1", "mant", longint'(outMant), 0);
    check("R1", "exp", longint'(int'(outExp)), 0);
  endtask

  task automatic testHold();
    logic [26:0] m0;
    logic signed [9:0] e0;
    logic s0;
    m0 = outMant; e0 = outExp; s0 = outSign;
    @(negedge clk);
    xMant = 24'hABCDEF; zMant = 24'h812345; xExp = 10'sd5; prodSign = ~prodSign;
    zIsZero = 1'b0; inValid = 1'b0;
    @(negedge clk);
    check("R2", "idle valid", longint'(outValid), 0);
    check("R2", "held mant", longint'(outMant), longint'(m0));
    check("R2", "held exp", longint'(int'(outExp)), longint'(int'(e0)));
    check("R2", "held sign", longint'(outSign), longint'(s0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runOp("R3", 24'h800000, 0, 24'hC00000, 0, 24'h800000, 0, 1, 0, 1, 0, 1, 0, 27'h6000000);
    runOp("R3", 24'hC00000, 0, 24'hC00000, 0, 24'h800000, 0, 0, 0, 1, 0, 0, 1, 27'h4800000);
    testHold();
    runOp("R9", 24'h800000, -200, 24'h800000, -100, 24'h800000, 0, 0, 0, 1, 0, 0, -300, 27'h4000000);
    runOp("R5", 24'h800000, 0, 24'h800000, 0, 24'h800000, -1, 0, 0, 0, 0, 0, 0, 27'h6000000);
    runOp("R5", 24'h800000, 0, 24'h800000, 0, 24'h800000, 0, 0, 0, 0, 0, 0, 1, 27'h4000000);
    runOp("R8", 24'h800001, 0, 24'h800001, 0, 24'h800000, 0, 0, 0, 0, 0, 0, 1, 27'h4000009);
    runOp("R4", 24'h800000, -100, 24'h800000, 0, 24'h800000, 0, 0, 0, 0, 0, 0, 0, 27'h4000001);
    runOp("R4", 24'h800000, -20, 24'h800000, 0, 24'h800000, 0, 0, 0, 0, 0, 0, 0, 27'h4000040);
    runOp("R8", 24'h800000, -40, 24'h800000, 0, 24'h800000, 0, 0, 0, 0, 0, 0, 0, 27'h4000001);
    runOp("R6", 24'h800000, 0, 24'h800000, 0, 24'hC00000, 0, 0, 1, 0, 0, 1, -1, 27'h4000000);
    runOp("R6", 24'h800000, 2, 24'h800000, 0, 24'h800000, 0, 0, 1, 0, 0, 0, 1, 27'h6000000);
    runOp("R6", 24'h800000, 0, 24'h800000, 0, 24'h800001, 0, 0, 1, 0, 0, 1, -23, 27'h4000000);
    runOp("R7", 24'h800000, 0, 24'h800000, 0, 24'h800000, 0, 0, 1, 0, 0, 0, 0, 27'h0);
    runOp("R7", 24'h800000, 0, 24'h800000, 0, 24'h800000, 0, 1, 0, 0, 1, 1, 0, 27'h0);
    testHold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule